// File: doc/BRIEF.md
# Weighted Random Path Selector

This block picks one of eight equal-cost uplinks for every outgoing packet of a flow. It makes a fresh decision per packet rather than once per flow, so a single large flow spreads across all uplinks instead of piling onto one. The switches report a queue depth for each uplink, and the selector reads these depths as live inputs. Each depth becomes a weight that is roughly inversely proportional to it, so an uplink with a queue ten times deeper gets about a tenth of the traffic.

The path is picked by a pseudo-random draw over the normalised weights, not by a fixed rotation. A fixed rotation would let senders that happen to be in step keep landing on the same spine together. A packet request is a one-cycle strobe. Two cycles later the block presents a registered path index with a valid strobe. It accepts one request per cycle, with no gaps needed between requests.

Top module: `spray_path_sel`

## Requirements
- R1: While reset is asserted, and after it has been released with no request made, `valid_o` is 0 and `path_o` is 0.
- R2: A request sampled with `req_i` high at a rising edge produces `valid_o` high for exactly one cycle, two rising edges later. A cycle without a request produces no `valid_o`. Requests may arrive on consecutive cycles.
- R3: The weight of path i is floor(255 / (d_i + 1)), where d_i is the 8-bit depth of path i in KB. A depth of 255 gives weight 0.
- R4: The random value comes from a 16-bit shift register. Each step it shifts left and feeds b15^b13^b12^b10 into bit 0. It holds 0xACE1 after reset, and it steps exactly once per accepted request and never otherwise, so the first request after reset draws 0xACE1.
- R5: With total weight T > 0 and random value r, the target is floor(r*T / 65536). The chosen path is the lowest index i whose running sum of weights over paths 0..i exceeds the target.
- R6: While T > 0, a path whose weight is 0 is never chosen.
- R7: When every weight is 0, the chosen path is r[2:0], taken from the same random value.
- R8: The depths are sampled on the same edge as the request. Depth changes on later cycles do not affect that request's result.
- R9: On `depth_i`, path i occupies bits [8i+7:8i], and the index on `path_o` is that same i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Per-packet path request strobe |
| depth_i | input | 64 | Queue depth in KB for each of the 8 paths, 8 bits each |
| valid_o | output | 1 | Path result strobe |
| path_o | output | 3 | Chosen path index |

## Verification
The hardest case to reach from the ports is the all-zero-weight fallback. It happens only when all eight depths sit at 255 at once on a request edge. The stimulus holds that pattern for a run of requests and checks each result against the low bits of an independent model of the random sequence. The cumulative-boundary cases are reached by keeping one path at depth 0 and sweeping a second path's depth while parking the others at zero weight. Because the random sequence is deterministic, every single draw has an exact expected path.

// File: rtl/spray_pkg.sv
package spray_pkg;
  localparam int unsigned DEF_PATHS   = 8;
  localparam int unsigned DEF_DEPTH_W = 8;
  localparam int unsigned DEF_WGT_W   = 8;
  localparam int unsigned DEF_RND_W   = 16;

  typedef enum logic {
    PICK_WEIGHTED = 1'b0,
    PICK_UNIFORM  = 1'b1
  } pick_mode_e;
endpackage

// File: rtl/spray_weight.sv
module spray_weight #(
  parameter int DEPTH_W = 8,
  parameter int WGT_W   = 8
) (
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [WGT_W-1:0]   weight_o
);
  localparam int QW = DEPTH_W + WGT_W + 1;
  localparam logic [QW-1:0] NUMER = QW'((2 ** WGT_W) - 1);

  logic [QW-1:0] denom;
  logic [QW-1:0] quot;
  logic          unused_quot_hi;

  // inverse-depth weight: full scale divided by (depth + 1)
  always_comb begin
    denom    = QW'(depth_i) + QW'(1);
    quot     = NUMER / denom;
    weight_o = quot[WGT_W-1:0];
  end

  assign unused_quot_hi = ^quot[QW-1:WGT_W];
endmodule

// File: rtl/spray_lfsr.sv
module spray_lfsr #(
  parameter int               RND_W = 16,
  parameter logic [RND_W-1:0] TAPS  = 16'hB400,
  parameter logic [RND_W-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [RND_W-1:0] state_o
);
  logic [RND_W-1:0] state_q;
  logic [RND_W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (adv_i) state_d = {state_q[RND_W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else if (adv_i) state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: the sequence steps only on an accepted request
  p_lfsr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_q));
  // R4: a nonzero seed never reaches the all-zero lockup state
  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/spray_pick.sv
module spray_pick
  import spray_pkg::*;
#(
  parameter  int NUM_PATHS = 8,
  parameter  int WGT_W     = 8,
  parameter  int RND_W     = 16,
  localparam int IDX_W     = $clog2(NUM_PATHS),
  localparam int SUM_W     = WGT_W + IDX_W
) (
  input  logic [NUM_PATHS*WGT_W-1:0] w_i,
  input  logic [RND_W-1:0]           rnd_i,
  output logic [IDX_W-1:0]           sel_o,
  output logic [SUM_W-1:0]           total_o,
  output pick_mode_e                 mode_o
);
  localparam int PROD_W = RND_W + SUM_W;

  logic [SUM_W-1:0]  total;
  logic [SUM_W-1:0]  cum;
  logic [SUM_W-1:0]  target;
  logic [PROD_W-1:0] prod;
  logic              found;
  logic              unused_prod_lo;

  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_PATHS; i++)
      total = total + SUM_W'(w_i[i*WGT_W +: WGT_W]);

    // scale the random value into [0, total)
    prod   = PROD_W'(rnd_i) * PROD_W'(total);
    target = prod[PROD_W-1:RND_W];

    // lowest path whose running weight passes the target
    cum   = '0;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < NUM_PATHS; i++) begin
      cum = cum + SUM_W'(w_i[i*WGT_W +: WGT_W]);
      if (!found && (cum > target)) begin
        sel_o = IDX_W'(i);
        found = 1'b1;
      end
    end

    if (total == '0) begin
      mode_o = PICK_UNIFORM;
      sel_o  = rnd_i[IDX_W-1:0];
    end else begin
      mode_o = PICK_WEIGHTED;
    end
    total_o = total;
  end

  assign unused_prod_lo = ^prod[RND_W-1:0];
endmodule

// File: rtl/spray_path_sel.sv
module spray_path_sel
  import spray_pkg::*;
#(
  parameter  int               NUM_PATHS = DEF_PATHS,
  parameter  int               DEPTH_W   = DEF_DEPTH_W,
  parameter  int               WGT_W     = DEF_WGT_W,
  parameter  int               RND_W     = DEF_RND_W,
  parameter  logic [RND_W-1:0] LFSR_TAPS = 16'hB400,
  parameter  logic [RND_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int               IDX_W     = $clog2(NUM_PATHS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_i,
  input  logic [NUM_PATHS*DEPTH_W-1:0] depth_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             path_o
);
  localparam int SUM_W = WGT_W + IDX_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-path weights from live depths
  logic [NUM_PATHS*WGT_W-1:0] w_now;

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_wgt
    spray_weight #(.DEPTH_W(DEPTH_W), .WGT_W(WGT_W)) u_wgt (
      .depth_i  (depth_i[g*DEPTH_W +: DEPTH_W]),
      .weight_o (w_now[g*WGT_W +: WGT_W])
    );
  end

  logic [RND_W-1:0] rnd_now;

  spray_lfsr #(.RND_W(RND_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .adv_i   (req_i),
    .state_o (rnd_now)
  );

  // stage 1: capture weights and random value on the request edge
  logic                       s1_vld_q, s1_vld_d;
  logic [NUM_PATHS*WGT_W-1:0] s1_w_q, s1_w_d;
  logic [RND_W-1:0]           s1_rnd_q, s1_rnd_d;

  always_comb begin
    s1_vld_d = req_i;
    s1_w_d   = w_now;
    s1_rnd_d = rnd_now;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_vld_q <= 1'b0;
      s1_w_q   <= '0;
      s1_rnd_q <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (req_i) begin
        s1_w_q   <= s1_w_d;
        s1_rnd_q <= s1_rnd_d;
      end
    end
  end

  // stage 2: weighted draw, registered result
  logic [IDX_W-1:0] pick_sel;
  logic [SUM_W-1:0] pick_total;
  pick_mode_e       pick_mode;

  spray_pick #(.NUM_PATHS(NUM_PATHS), .WGT_W(WGT_W), .RND_W(RND_W)) u_pick (
    .w_i     (s1_w_q),
    .rnd_i   (s1_rnd_q),
    .sel_o   (pick_sel),
    .total_o (pick_total),
    .mode_o  (pick_mode)
  );

  logic             vld_d;
  logic [IDX_W-1:0] path_d;

  always_comb begin
    vld_d  = s1_vld_q;
    path_d = pick_sel;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_o <= 1'b0;
      path_o  <= '0;
    end else begin
      valid_o <= vld_d;
      if (s1_vld_q) path_o <= path_d;
    end
  end

  // R2: result strobe two edges after each request
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_i |=> ##1 valid_o);
  // R2: no strobe without a request
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_i |=> ##1 !valid_o);
  // R6: a zero-weight path is never the draw result while any weight is live
  p_zero_weight_skip_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (s1_vld_q && pick_total != '0) |-> (s1_w_q[pick_sel*WGT_W +: WGT_W] != '0));
  // R7: all-zero weights fall back to the low random bits
  p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (s1_vld_q && pick_mode == PICK_UNIFORM) |=> (path_o == $past(s1_rnd_q[IDX_W-1:0])));
endmodule

// File: tb/tb_spray_path_sel.sv
module tb_spray_path_sel;
  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [63:0] depth_i;
  logic        valid_o;
  logic [2:0]  path_o;

  spray_path_sel dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .depth_i (depth_i),
    .valid_o (valid_o),
    .path_o  (path_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  logic [15:0] m_lfsr;
  bit    pv   [2];
  int    pp   [2];
  string ptag [2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input logic [63:0] d, input logic [15:0] r);
    int w[8];
    int tot = 0;
    int cum = 0;
    longint tgt;
    for (int i = 0; i < 8; i++) begin
      w[i] = 255 / (int'(d[8*i +: 8]) + 1);
      tot += w[i];
    end
    if (tot == 0) return int'(r[2:0]);
    tgt = (longint'(r) * longint'(tot)) >>> 16;
    for (int i = 0; i < 8; i++) begin
      cum += w[i];
      if (longint'(cum) > tgt) return i;
    end
    return -1;
  endfunction

  // one cycle: check result due now, then drive next inputs
  task automatic step(input bit r, input logic [63:0] d, input string tag);
    @(negedge clk);
    check(valid_o == pv[1], "R2 valid", int'(valid_o), int'(pv[1]));
    if (pv[1]) check(int'(path_o) == pp[1], ptag[1], int'(path_o), pp[1]);
    pv[1] = pv[0]; pp[1] = pp[0]; ptag[1] = ptag[0];
    pv[0] = r; pp[0] = 0; ptag[0] = tag;
    if (r) begin
      pp[0]  = model_pick(d, m_lfsr);
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
    req_i   = r;
    depth_i = d;
  endtask

  initial begin
    logic [63:0] d;
    rst_n = 1'b0; req_i = 1'b0; depth_i = '0;
    m_lfsr = 16'hACE1;
    pv[0] = 0; pv[1] = 0; pp[0] = 0; pp[1] = 0; ptag[0] = ""; ptag[1] = "";
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(path_o == 3'd0, "R1 path in reset", int'(path_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid after release", int'(valid_o), 0);
    check(path_o == 3'd0, "R1 path after release", int'(path_o), 0);

    // R5: equal depths across all paths
    foreach (d[i]) d[i] = 1'b0;
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'((v == 0) ? 0 : (v == 1) ? 1 : (v == 2) ? 9 : 100);
      for (int c = 0; c < 40; c++) step(1'b1, d, "R5 equal depths");
    end

    // R3: path 0 empty, path k swept, rest at zero weight
    for (int k = 1; k < 8; k++)
      for (int dv = 0; dv < 255; dv += 7) begin
        for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'd255;
        d[7:0] = 8'd0;
        d[8*k +: 8] = 8'(dv);
        step(1'b1, d, "R3 inverse weight sweep");
      end

    // R6: one path at zero weight, others varied
    for (int j = 0; j < 8; j++)
      for (int c = 0; c < 30; c++) begin
        for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'((i * 37 + c * 11) % 255);
        d[8*j +: 8] = 8'd255;
        step(1'b1, d, "R6 zero-weight path skipped");
      end

    // R7: every weight zero
    for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'd255;
    for (int c = 0; c < 64; c++) step(1'b1, d, "R7 uniform fallback");

    // R9: only path k attractive, others weight 1
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 12; c++) begin
        for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'd200;
        d[8*k +: 8] = 8'd0;
        step(1'b1, d, "R9 path lane order");
      end

    // R4: sparse requests with idle gaps must not step the sequence
    for (int c = 0; c < 600; c++) begin
      for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'((c * 13 + i * 29) % 256);
      step((c % 3) == 0, d, "R4 sequence steps per request");
    end

    // R8: depths change every cycle, result follows request-edge depths
    for (int c = 0; c < 800; c++) begin
      for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'((c * (i + 3) * 7 + i * 51) % 256);
      step((c % 5) != 2, d, "R8 depth sampled with request");
    end

    for (int i = 0; i < 8; i++) d[8*i +: 8] = 8'd0;
    repeat (3) step(1'b0, d, "R2 flush");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule